// File: doc/BRIEF.md
# Frame-to-Link Octet Width Adaptor

This block sits between an application data path that produces one whole frame per lane at a time and a link-side consumer that takes one 32-bit word per lane on each link clock cycle. A frame holds `FRAME_OCTETS` octets for each of `LANES` lanes. On the input bus, lane `i` occupies a contiguous slice, and inside that slice octet `j` (octet 0 is the oldest) sits at bits `[8j+7:8j]`. The adaptor captures a frame when the frame strobe meets its ready signal. It puts every lane into big-endian order at capture time. It then plays the frame out over `FRAME_OCTETS/4` consecutive cycles.

Everything runs on one clock. The frame side uses a valid/ready pair. The link side has no backpressure: a valid flag accompanies each word and a start-of-frame flag marks each frame's first word. The controller has two states. `ST_IDLE` means nothing is being emitted. `ST_STREAM` means one word per cycle is on the output. It has four transitions:

- `T_START`: `ST_IDLE` to `ST_STREAM` when a frame is accepted.
- `T_ADVANCE`: `ST_STREAM` to `ST_STREAM` with the word index incremented.
- `T_CHAIN`: `ST_STREAM` to `ST_STREAM`, with the index reset to 0, when a new frame is accepted while the last word is out.
- `T_DRAIN`: `ST_STREAM` to `ST_IDLE` after the last word when no new frame arrives.

A frame size that is not a positive multiple of four is rejected at elaboration.

Top module: `f2l_octet_adaptor`

## Requirements
- R1: During and right after reset, `link_valid` is 0 and `frame_ready` is 1.
- R2: A frame accepted at a clock edge (`frame_valid` and `frame_ready` both 1) makes `link_valid` and `link_sof` 1 in the following cycle.
- R3: Output word k of a frame carries frame octets 4k to 4k+3 of each lane. Octet 4k is in bits [31:24] of the lane word, 4k+1 in [23:16], 4k+2 in [15:8] and 4k+3 in [7:0].
- R4: Lane i's word is placed on `link_data[32i+31:32i]`, so lane 0 is in the least significant 32 bits.
- R5: Each frame produces exactly `FRAME_OCTETS/4` consecutive valid cycles. `link_sof` is 1 only on the first of them.
- R6: `frame_ready` is 0 from the cycle after acceptance until the cycle in which the frame's last word is on `link_data`. It is 1 in that cycle, so frames can follow back to back with no gap.
- R7: `frame_valid` and `frame_data` are ignored while `frame_ready` is 0. The word stream of the frame in flight is not altered.
- R8: If no frame is accepted while the last word is out, `link_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | Frame strobe: a new frame is offered |
| frame_ready | output | 1 | Adaptor can accept a frame this cycle |
| frame_data | input | LANES*FRAME_OCTETS*8 | Frame, lane i at slice i, octet 0 lowest |
| link_valid | output | 1 | A link word is present |
| link_sof | output | 1 | First word of a frame |
| link_data | output | LANES*32 | One big-endian word per lane, lane 0 lowest |

## Verification
A corrupted word index moves whole 32-bit groups. Octets then show up in the wrong word on the very next valid cycle, and `link_sof` appears at the wrong place in the stream. A wrong state or a wrong last-word decode shows up on `frame_ready` in the same cycle. It also shows up one cycle later as a frame that is one word too short or too long, a missing idle cycle, or a lost back-to-back frame. The bench runs a queue-based model next to the design and compares valid, start-of-frame, data and ready on every cycle, so any such fault is reported within one cycle of reaching the ports.

// File: rtl/f2l_pkg.sv
package f2l_pkg;

    localparam int OCTET_W     = 8;
    localparam int WORD_OCTETS = 4;
    localparam int WORD_W      = OCTET_W * WORD_OCTETS;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_STREAM = 1'b1
    } f2l_state_e;

    // Four consecutive frame octets packed with the oldest at the top byte.
    function automatic logic [WORD_W-1:0] pack_big_endian(
        input logic [OCTET_W-1:0] oldest,
        input logic [OCTET_W-1:0] second,
        input logic [OCTET_W-1:0] third,
        input logic [OCTET_W-1:0] newest
    );
        return {oldest, second, third, newest};
    endfunction

endpackage

// File: rtl/f2l_swizzle.sv
module f2l_swizzle
    import f2l_pkg::*;
#(
    parameter int LANES        = 2,
    parameter int FRAME_OCTETS = 8
) (
    input  logic [LANES*FRAME_OCTETS*OCTET_W-1:0]                 frame_i,
    output logic [(FRAME_OCTETS/WORD_OCTETS)*LANES*WORD_W-1:0]    words_o
);

    localparam int WORDS   = FRAME_OCTETS / WORD_OCTETS;
    localparam int LANE_W  = FRAME_OCTETS * OCTET_W;
    localparam int STRIPE  = LANES * WORD_W;

    // Word k of the frame forms stripe k; inside a stripe lane i is slot i.
    for (genvar k = 0; k < WORDS; k++) begin : g_word
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            localparam int BASE = i * LANE_W + k * WORD_OCTETS * OCTET_W;
            assign words_o[k*STRIPE + i*WORD_W +: WORD_W] = pack_big_endian(
                frame_i[BASE + 0*OCTET_W +: OCTET_W],
                frame_i[BASE + 1*OCTET_W +: OCTET_W],
                frame_i[BASE + 2*OCTET_W +: OCTET_W],
                frame_i[BASE + 3*OCTET_W +: OCTET_W]
            );
        end
    end

endmodule

// File: rtl/f2l_ctrl.sv
module f2l_ctrl
    import f2l_pkg::*;
#(
    parameter int WORDS = 2,
    localparam int CW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid_i,
    output logic          in_ready_o,
    output logic          load_o,
    output logic          valid_o,
    output logic          sof_o,
    output logic [CW-1:0] idx_o
);

    localparam logic [CW-1:0] IDX_LAST = CW'(WORDS - 1);

    f2l_state_e    state_q, state_d;
    logic [CW-1:0] idx_q,   idx_d;
    logic          at_last;
    logic          accept;

    assign at_last = (idx_q == IDX_LAST);
    assign accept  = in_valid_i && in_ready_o;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Transitions: T_START, T_ADVANCE, T_CHAIN, T_DRAIN
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin          // T_START
                    state_d = ST_STREAM;
                    idx_d   = '0;
                end
            end
            ST_STREAM: begin
                if (!at_last) begin        // T_ADVANCE
                    idx_d = idx_q + 1'b1;
                end else if (accept) begin // T_CHAIN
                    state_d = ST_STREAM;
                    idx_d   = '0;
                end else begin             // T_DRAIN
                    state_d = ST_IDLE;
                    idx_d   = '0;
                end
            end
            default: begin
                state_d = ST_IDLE;
                idx_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        in_ready_o = 1'b0;
        valid_o    = 1'b0;
        sof_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready_o = 1'b1;
            end
            ST_STREAM: begin
                in_ready_o = at_last;
                valid_o    = 1'b1;
                sof_o      = (idx_q == '0);
            end
            default: begin
                in_ready_o = 1'b0;
            end
        endcase
    end

    assign load_o = accept;
    assign idx_o  = idx_q;

endmodule

// File: rtl/f2l_wordsel.sv
module f2l_wordsel
    import f2l_pkg::*;
#(
    parameter int LANES = 2,
    parameter int WORDS = 2,
    localparam int CW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_i,
    input  logic [WORDS*LANES*WORD_W-1:0] words_i,
    input  logic [CW-1:0]                 idx_i,
    output logic [LANES*WORD_W-1:0]       word_o
);

    localparam int STRIPE = LANES * WORD_W;

    logic [WORDS*STRIPE-1:0] hold_q;
    logic [STRIPE-1:0]       stripe [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (load_i) begin
            hold_q <= words_i;
        end
    end

    for (genvar k = 0; k < WORDS; k++) begin : g_stripe
        assign stripe[k] = hold_q[k*STRIPE +: STRIPE];
    end

    always_comb begin
        word_o = '0;
        for (int k = 0; k < WORDS; k++) begin
            if (idx_i == CW'(k)) begin
                word_o = stripe[k];
            end
        end
    end

endmodule

// File: rtl/f2l_octet_adaptor.sv
module f2l_octet_adaptor
    import f2l_pkg::*;
#(
    parameter int LANES        = 2,
    parameter int FRAME_OCTETS = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                frame_valid,
    output logic                                frame_ready,
    input  logic [LANES*FRAME_OCTETS*8-1:0]     frame_data,
    output logic                                link_valid,
    output logic                                link_sof,
    output logic [LANES*32-1:0]                 link_data
);

    localparam int WORDS = FRAME_OCTETS / WORD_OCTETS;
    localparam int CW    = (WORDS > 1) ? $clog2(WORDS) : 1;

    if ((FRAME_OCTETS < WORD_OCTETS) || (FRAME_OCTETS % WORD_OCTETS != 0)) begin : g_bad_frame
        $error("FRAME_OCTETS must be a positive multiple of 4");
    end

    logic [WORDS*LANES*WORD_W-1:0] swizzled;
    logic                          load;
    logic [CW-1:0]                 idx;

    f2l_swizzle #(
        .LANES        (LANES),
        .FRAME_OCTETS (FRAME_OCTETS)
    ) u_swizzle (
        .frame_i (frame_data),
        .words_o (swizzled)
    );

    f2l_ctrl #(
        .WORDS (WORDS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid_i (frame_valid),
        .in_ready_o (frame_ready),
        .load_o     (load),
        .valid_o    (link_valid),
        .sof_o      (link_sof),
        .idx_o      (idx)
    );

    f2l_wordsel #(
        .LANES (LANES),
        .WORDS (WORDS)
    ) u_wordsel (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .words_i (swizzled),
        .idx_i   (idx),
        .word_o  (link_data)
    );

endmodule

// File: rtl/f2l_octet_adaptor_chk.sv
module f2l_octet_adaptor_chk #(
    parameter int FRAME_OCTETS = 8
) (
    input logic clk,
    input logic rst_n,
    input logic frame_valid,
    input logic frame_ready,
    input logic link_valid,
    input logic link_sof
);

    localparam int WORDS = FRAME_OCTETS / 4;

    int seen;   // words of the current frame already emitted
    int pos;    // position of the word now on the output

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= 0;
        end else if (link_valid) begin
            seen <= link_sof ? 1 : seen + 1;
        end
    end

    assign pos = link_sof ? 0 : seen;

    p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !link_valid |-> frame_ready);

    p_sof_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && frame_ready) |=> (link_valid && link_sof));

    p_sof_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        link_sof |-> link_valid);

    p_sof_after_full_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (link_valid && link_sof) |-> (seen == 0 || seen == WORDS));

    p_mid_frame_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (link_valid && !link_sof) |-> (seen >= 1 && seen < WORDS));

    p_ready_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        link_valid |-> (frame_ready == (pos == WORDS - 1)));

    p_drain_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (link_valid && pos == WORDS - 1 && !frame_valid) |=> !link_valid);

endmodule

bind f2l_octet_adaptor f2l_octet_adaptor_chk #(
    .FRAME_OCTETS (FRAME_OCTETS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .frame_ready (frame_ready),
    .link_valid  (link_valid),
    .link_sof    (link_sof)
);

// File: tb/f2l_octet_adaptor_tb.sv
`timescale 1ns/1ps
module f2l_octet_adaptor_tb;

    localparam int LANES = 2;
    localparam int FO    = 16;
    localparam int WORDS = FO / 4;
    localparam int IW    = LANES * FO * 8;
    localparam int OW    = LANES * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_valid = 1'b0;
    logic          frame_ready;
    logic [IW-1:0] frame_data = '0;
    logic          link_valid;
    logic          link_sof;
    logic [OW-1:0] link_data;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    bit            q_sof [$];
    logic [OW-1:0] q_dat [$];

    always #2.5 clk = ~clk;

    f2l_octet_adaptor #(.LANES(LANES), .FRAME_OCTETS(FO)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_valid (frame_valid),
        .frame_ready (frame_ready),
        .frame_data  (frame_data),
        .link_valid  (link_valid),
        .link_sof    (link_sof),
        .link_data   (link_data)
    );

    task automatic chk(input bit ok, input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    function automatic logic [7:0] octet(input logic [IW-1:0] f, input int lane, input int j);
        return f[(lane*FO + j)*8 +: 8];
    endfunction

    // Expected words per R3 (octet 4k at the top byte) and R4 (lane 0 lowest)
    task automatic push_frame(input logic [IW-1:0] f);
        for (int k = 0; k < WORDS; k++) begin
            logic [OW-1:0] w;
            for (int i = 0; i < LANES; i++) begin
                w[i*32 + 24 +: 8] = octet(f, i, 4*k);
                w[i*32 + 16 +: 8] = octet(f, i, 4*k + 1);
                w[i*32 +  8 +: 8] = octet(f, i, 4*k + 2);
                w[i*32 +  0 +: 8] = octet(f, i, 4*k + 3);
            end
            q_dat.push_back(w);
            q_sof.push_back(k == 0);
        end
    endtask

    function automatic logic [IW-1:0] rand_frame();
        logic [IW-1:0] f;
        for (int b = 0; b < IW/8; b++) f[b*8 +: 8] = 8'($urandom);
        return f;
    endfunction

    // One cycle: compare outputs, drive inputs for the next edge, advance model
    task automatic step(input bit v, input logic [IW-1:0] d);
        bit exp_valid, exp_ready, acc;
        @(negedge clk);
        exp_valid = (q_dat.size() > 0);
        exp_ready = (q_dat.size() <= 1);
        chk(link_valid == exp_valid, "R2 R5 R8 link_valid", OW'(link_valid), OW'(exp_valid));
        chk(frame_ready == exp_ready, "R6 frame_ready", OW'(frame_ready), OW'(exp_ready));
        if (exp_valid) begin
            chk(link_sof == q_sof[0], "R2 R5 link_sof", OW'(link_sof), OW'(q_sof[0]));
            chk(link_data == q_dat[0], "R3 R4 R7 link_data", link_data, q_dat[0]);
        end
        frame_valid = v;
        frame_data  = d;
        acc = v && exp_ready;   // R7: offers while not ready are dropped
        if (q_dat.size() > 0) begin
            void'(q_dat.pop_front());
            void'(q_sof.pop_front());
        end
        if (acc) push_frame(d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [IW-1:0] f;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(link_valid == 1'b0, "R1 link_valid in reset", OW'(link_valid), '0);
        chk(frame_ready == 1'b1, "R1 frame_ready in reset", OW'(frame_ready), OW'(1));
        rst_n = 1'b1;
        @(negedge clk);
        chk(link_valid == 1'b0, "R1 link_valid after reset", OW'(link_valid), '0);
        chk(frame_ready == 1'b1, "R1 frame_ready after reset", OW'(frame_ready), OW'(1));

        // Directed frame: octet value encodes lane and index (R3, R4)
        for (int i = 0; i < LANES; i++)
            for (int j = 0; j < FO; j++)
                f[(i*FO + j)*8 +: 8] = 8'((i << 5) | j);
        step(1, f);
        repeat (WORDS + 3) step(0, '0);   // drain then idle (R8)

        // R7: hold strobe with changing data while busy, then release
        step(1, rand_frame());
        repeat (WORDS - 1) step(1, rand_frame());
        repeat (WORDS + 2) step(0, '0);

        // R6: back-to-back frames with the strobe held high
        repeat (10 * WORDS) step(1, rand_frame());
        repeat (WORDS + 2) step(0, '0);

        // Irregular gaps
        for (int n = 0; n < 300; n++) step(($urandom % 3) == 0, rand_frame());
        repeat (WORDS + 3) step(0, '0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule